// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the host-facing side of a small timekeeping register bank. A host talks to it over three signals: an enable line that frames each transfer, a serial clock, and one data line that both sides share. The block holds eight bytes. Addresses 0 to 6 are general timekeeping bytes. Address 7 carries a single write-lock flag in its top bit.

Every framed transfer opens with an 8-bit command sent least significant bit first. The command says whether the transfer reads or writes. It then either names one register or asks for all eight in sequence from address 0. Write data is sampled on rising serial-clock edges. Read data leaves the block one bit per falling edge, and only during that phase is the data line driven. The serial clock, enable and data input are brought into the system clock domain through a synchronizer, and their edges are detected there.

The shared line is split into an input, an output and an output-enable, so the pad buffer stays outside the block. Dropping the enable at any point ends the transfer at once.

Top module: `tw_serial_regs`

## Requirements
- R1: The command byte is shifted in LSB first on rising serial-clock edges. Command bit 0 selects the direction (0 write, 1 read), and bits 3..1 give the register address. A single-register command has bits 7..4 equal to 1000.
- R2: A single write stores the following byte, received LSB first, into the addressed register once its eighth bit has been sampled.
- R3: A single read drives the addressed byte LSB first, one bit after each falling serial-clock edge. The output-enable is high only during that read data phase.
- R4: Command 0xBE (10111110) writes eight consecutive bytes into addresses 0 to 7 in order.
- R5: Command 0xBF (10111111) reads addresses 0 to 7 back to back, each LSB first.
- R6: Address 7 keeps only its bit 7, which is the write-lock flag. Its bits 6..0 always read 0.
- R7: While the write-lock flag is 1, writes to addresses 0 to 6 leave those registers unchanged.
- R8: Address 7 accepts writes even while the lock is set, so the lock can be cleared.
- R9: Commands of the form 1001xxx1 are no-ops. They write nothing and never drive the data line.
- R10: A command with bit 7 equal to 0 makes the block ignore every further bit until the enable is deasserted and asserted again.
- R11: Deasserting the enable releases the data line within the synchronizer latency plus one cycle. It also discards any partly received byte.
- R12: After reset all eight registers read 0 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Transfer enable, active high; framing for one transfer |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Data line as seen at the pad input |
| sdio_out | output | 1 | Data bit driven onto the line during reads |
| sdio_oe | output | 1 | Output-enable for the data line pad driver |

## Verification
The bench first fills registers through single writes and reads each one back. It then sets the lock and repeats writes that must bounce, which catches a lock that also blocks address 7 or one that fails to block the others. A burst write followed by a burst read exposes an address counter that does not advance, wraps early or starts away from 0. Test codes, commands with a clear top bit, and a valid command sent after a clear-top-bit command in the same frame must leave registers untouched and the line released. A design that keeps decoding would show a changed register or a raised output-enable. Transfers cut short by dropping the enable must neither commit a half byte nor keep driving the line.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_IGN,
        ST_DONE
    } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   we,
    input  logic [ADDR_W-1:0]                      waddr,
    input  logic [DATA_W-1:0]                      wdata,
    output logic [(1<<ADDR_W)-1:0][DATA_W-1:0]     contents
);
    localparam int NREG = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LOCK_ADDR = '1;

    logic [NREG-2:0][DATA_W-1:0] mem_d, mem_q;
    logic                        lock_d, lock_q;

    always_comb begin
        mem_d  = mem_q;
        lock_d = lock_q;
        if (we) begin
            if (waddr == LOCK_ADDR) lock_d = wdata[DATA_W-1];
            else if (!lock_q)       mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            mem_q  <= mem_d;
            lock_q <= lock_d;
        end
    end

    for (genvar g = 0; g < NREG - 1; g++) begin : g_data
        assign contents[g] = mem_q[g];
    end
    assign contents[NREG-1] = {lock_q, {(DATA_W-1){1'b0}}};
endmodule

// File: rtl/tw_serial_regs.sv
module tw_serial_regs
    import tw_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sclk,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe
);
    localparam int NREG  = 1 << ADDR_W;
    localparam int CNT_W = $clog2(DATA_W) + 1;
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0]  FULL_BYTE = CNT_W'(DATA_W);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
    localparam logic [5:0]        BURST_CODE = 6'b011111;

    typedef struct packed {
        tw_state_e          st;
        logic [DATA_W-1:0]  sr;
        logic [CNT_W-1:0]   bcnt;
        logic [ADDR_W-1:0]  addr;
        logic               burst;
        logic               oe;
        logic               dout;
        logic               sclk_prev;
    } ctl_t;

    ctl_t q, d;

    logic [2:0] syn;
    logic       ce_s, sclk_s, din_s, rise, fall;

    tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce, sclk, sdio_in}),
        .q     (syn)
    );
    assign ce_s   = syn[2];
    assign sclk_s = syn[1];
    assign din_s  = syn[0];
    assign rise   = sclk_s & ~q.sclk_prev;
    assign fall   = ~sclk_s & q.sclk_prev;

    logic                                rf_we;
    logic [ADDR_W-1:0]                   rf_waddr;
    logic [DATA_W-1:0]                   rf_wdata;
    logic [NREG-1:0][DATA_W-1:0]         rf_contents;
    tw_state_e                           st_cur;

    tw_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (rf_we),
        .waddr    (rf_waddr),
        .wdata    (rf_wdata),
        .contents (rf_contents)
    );

    logic [DATA_W-1:0] nsr, cur_byte, nxt_byte;
    logic [ADDR_W-1:0] nxt_addr;

    always_comb begin
        d           = q;
        d.sclk_prev = sclk_s;
        rf_we       = 1'b0;
        rf_waddr    = q.addr;
        rf_wdata    = '0;
        nsr         = {din_s, q.sr[DATA_W-1:1]};
        nxt_addr    = q.addr + ADDR_W'(1);
        cur_byte    = rf_contents[q.addr];
        nxt_byte    = rf_contents[nxt_addr];

        if (!ce_s) begin
            d.st   = ST_IDLE;
            d.oe   = 1'b0;
            d.bcnt = '0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    d.st   = ST_CMD;
                    d.bcnt = '0;
                end
                ST_CMD: if (rise) begin
                    d.sr = nsr;
                    if (q.bcnt == LAST_BIT) begin
                        d.bcnt  = '0;
                        d.burst = 1'b0;
                        if (!nsr[DATA_W-1]) begin
                            d.st = ST_IGN;
                        end else if (nsr[6:1] == BURST_CODE) begin
                            d.burst = 1'b1;
                            d.addr  = '0;
                            d.st    = nsr[0] ? ST_RD : ST_WR;
                        end else if (nsr[6:ADDR_W+1] == '0) begin
                            d.addr = nsr[ADDR_W:1];
                            d.st   = nsr[0] ? ST_RD : ST_WR;
                        end else begin
                            d.st = ST_IGN;
                        end
                    end else begin
                        d.bcnt = q.bcnt + CNT_W'(1);
                    end
                end
                ST_WR: if (rise) begin
                    d.sr = nsr;
                    if (q.bcnt == LAST_BIT) begin
                        rf_we    = 1'b1;
                        rf_wdata = nsr;
                        d.bcnt   = '0;
                        if (q.burst && q.addr != LAST_ADDR) d.addr = nxt_addr;
                        else                                d.st   = ST_DONE;
                    end else begin
                        d.bcnt = q.bcnt + CNT_W'(1);
                    end
                end
                ST_RD: if (fall) begin
                    if (!q.oe) begin
                        d.oe   = 1'b1;
                        d.dout = cur_byte[0];
                        d.sr   = {1'b0, cur_byte[DATA_W-1:1]};
                        d.bcnt = CNT_W'(1);
                    end else if (q.bcnt != FULL_BYTE) begin
                        d.dout = q.sr[0];
                        d.sr   = {1'b0, q.sr[DATA_W-1:1]};
                        d.bcnt = q.bcnt + CNT_W'(1);
                    end else if (q.burst && q.addr != LAST_ADDR) begin
                        d.addr = nxt_addr;
                        d.dout = nxt_byte[0];
                        d.sr   = {1'b0, nxt_byte[DATA_W-1:1]};
                        d.bcnt = CNT_W'(1);
                    end else begin
                        d.oe = 1'b0;
                        d.st = ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign sdio_out = q.dout;
    assign sdio_oe  = q.oe;
    assign st_cur   = q.st;
endmodule

// File: rtl/tw_serial_regs_chk.sv
module tw_serial_regs_chk
    import tw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                ce_s,
    input logic                                oe,
    input tw_state_e                           st,
    input logic                                we,
    input logic [ADDR_W-1:0]                   waddr,
    input logic [DATA_W-1:0]                   wdata,
    input logic [(1<<ADDR_W)-1:0][DATA_W-1:0]  contents
);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = '1;

    // R11
    ce_low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> !oe);

    // R3
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> st == ST_RD);

    // R7
    lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && contents[LOCK_ADDR][DATA_W-1] && waddr != LOCK_ADDR) |=> $stable(contents));

    // R8
    lock_writable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == LOCK_ADDR) |=> contents[LOCK_ADDR][DATA_W-1] == $past(wdata[DATA_W-1]));

    // R10
    ignore_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IGN |-> !we && !oe);
endmodule

bind tw_serial_regs tw_serial_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_s     (ce_s),
    .oe       (sdio_oe),
    .st       (st_cur),
    .we       (rf_we),
    .waddr    (rf_waddr),
    .wdata    (rf_wdata),
    .contents (rf_contents)
);

// File: tb/sim_tw_serial_regs.sv
module sim_tw_serial_regs;
    localparam int HALF = 10;
    localparam int WD   = 150000;
    localparam int NVEC = 10;
    // {addr, write data, expected read-back}
    localparam logic [18:0] VEC [NVEC] = '{
        {3'd0, 8'h59, 8'h59},   // R2
        {3'd1, 8'h3A, 8'h3A},   // R2 R1
        {3'd2, 8'h92, 8'h92},   // R2
        {3'd6, 8'h99, 8'h99},   // R2
        {3'd7, 8'h7F, 8'h00},   // R6
        {3'd7, 8'h80, 8'h80},   // R6 lock on
        {3'd4, 8'h12, 8'h00},   // R7 refused
        {3'd0, 8'h00, 8'h59},   // R7 refused
        {3'd7, 8'h00, 8'h00},   // R8 lock off
        {3'd4, 8'h12, 8'h12}    // R8 accepted again
    };

    logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sclk = 1'b0, sdio_in = 1'b0;
    logic sdio_out, sdio_oe;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    tw_serial_regs u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe)
    );

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bit_io(input logic b, output logic o, output logic e);
        sclk = 1'b0; sdio_in = b;
        wait_n(HALF);
        o = sdio_out; e = sdio_oe;
        sclk = 1'b1;
        wait_n(HALF);
    endtask

    task automatic start_x();
        ce = 1'b1; wait_n(HALF);
    endtask

    task automatic stop_x();
        sclk = 1'b0; wait_n(HALF);
        ce = 1'b0; wait_n(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic any_oe);
        logic o, e;
        any_oe = 1'b0;
        for (int i = 0; i < 8; i++) begin
            bit_io(v[i], o, e);
            any_oe |= e;
        end
    endtask

    task automatic recv_byte(output logic [7:0] v, output logic all_oe);
        logic o, e;
        all_oe = 1'b1;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b0, o, e);
            v[i] = o;
            all_oe &= e;
        end
    endtask

    task automatic wr1(input logic [2:0] a, input logic [7:0] v);
        logic x;
        start_x();
        send_byte({4'b1000, a, 1'b0}, x);
        send_byte(v, x);
        stop_x();
    endtask

    task automatic rd1(input logic [2:0] a, output logic [7:0] v, output logic all_oe);
        logic x;
        start_x();
        send_byte({4'b1000, a, 1'b1}, x);
        recv_byte(v, all_oe);
        stop_x();
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", checks);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic e, x;
        logic [7:0] bw [8];
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);

        // R12: reset state
        chk(sdio_oe == 1'b0, "R12 oe after reset", {7'b0, sdio_oe}, 8'h00);
        for (int a = 0; a < 8; a++) begin
            rd1(3'(a), v, e);
            chk(v == 8'h00, "R12 register after reset", v, 8'h00);
        end

        // table walk: single writes and read-back (R1 R2 R3 R6 R7 R8)
        for (int i = 0; i < NVEC; i++) begin
            wr1(VEC[i][18:16], VEC[i][15:8]);
            rd1(VEC[i][18:16], v, e);
            chk(v == VEC[i][7:0], $sformatf("R2/R6/R7/R8 vector %0d", i), v, VEC[i][7:0]);
            chk(e, "R3 oe during read data", {7'b0, e}, 8'h01);
        end

        // R4 R5: burst write then burst read
        for (int i = 0; i < 7; i++) bw[i] = 8'(i + 1);
        bw[7] = 8'h00;
        start_x();
        send_byte(8'hBE, x);
        for (int i = 0; i < 8; i++) send_byte(bw[i], x);
        stop_x();
        start_x();
        send_byte(8'hBF, x);
        chk(!x, "R3 oe low during command", {7'b0, x}, 8'h00);
        for (int i = 0; i < 8; i++) begin
            recv_byte(v, e);
            chk(v == bw[i] && e, $sformatf("R4/R5 burst byte %0d", i), v, bw[i]);
        end
        stop_x();
        chk(sdio_oe == 1'b0, "R3 oe released after burst", {7'b0, sdio_oe}, 8'h00);

        // R9: test code 1001_001_1 is a no-op
        start_x();
        send_byte(8'h93, x);
        send_byte(8'hFF, x);
        chk(!x, "R9 test code drove line", {7'b0, x}, 8'h00);
        stop_x();
        rd1(3'd1, v, e);
        chk(v == 8'h02, "R9 register after test code", v, 8'h02);

        // R10: clear top bit, then a valid command in the same frame
        start_x();
        send_byte(8'h04, x);
        send_byte(8'hFF, x);
        send_byte(8'h84, x);
        send_byte(8'hAA, x);
        chk(!x, "R10 ignored frame drove line", {7'b0, x}, 8'h00);
        stop_x();
        rd1(3'd2, v, e);
        chk(v == 8'h03, "R10 register after ignored frame", v, 8'h03);
        wr1(3'd2, 8'hAA);
        rd1(3'd2, v, e);
        chk(v == 8'hAA, "R10 accepted after new frame", v, 8'hAA);

        // R11: aborted write leaves register unchanged
        start_x();
        send_byte(8'h86, x);
        for (int i = 0; i < 4; i++) bit_io(1'b1, x, e);
        stop_x();
        rd1(3'd3, v, e);
        chk(v == 8'h04, "R11 aborted write", v, 8'h04);

        // R11: aborted read releases line
        start_x();
        send_byte(8'h8B, x);
        for (int i = 0; i < 3; i++) bit_io(1'b0, x, e);
        chk(e, "R11 oe high before abort", {7'b0, e}, 8'h01);
        ce = 1'b0;
        wait_n(6);
        chk(sdio_oe == 1'b0, "R11 oe after enable drop", {7'b0, sdio_oe}, 8'h00);
        sclk = 1'b0;
        wait_n(HALF);
        rd1(3'd5, v, e);
        chk(v == 8'h06, "R11 read after abort", v, 8'h06);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule